// File: doc/BRIEF.md
# Self-Timed Programming Sequencer with Ready/Busy Status

This block sits behind the serial command decoder of a small serial non-volatile memory. It receives decoded programming requests and carries them out on the storage array through a single word-wide write port. The requests are single-word write, single-word erase, write of one pattern to every word, and erase of every word. It also keeps the write-enable guard latch. The latch comes out of reset cleared, and every programming request is refused while it is clear.

An accepted request waits until chip select falls. The falling edge starts a busy period of programmable length that models the self-timed program cycle. When the timer runs out, the array is committed: one cycle for a single word, or one cycle per word while an address counter walks the whole array. If chip select is raised again after a cycle has started, the serial data output reports the cycle state: busy reads 0 and done reads 1. A rising serial clock edge taken while chip select and DIN are both high clears this report. Requests that arrive during a cycle are discarded, and a sticky flag records each one.

Chip select, DIN and the serial clock are sampled through a synchronizer of `SYNC_STAGES` flops. Requests arrive in the system clock domain as one-cycle strobes.

Top module: `prog_seq`

## Requirements
- R1: After reset, `wen_o`, `busy_o`, `drop_err_o`, `status_oe_o` and `mem_we_o` are all 0.
- R2: A programming request (`req_op_i` 3 = write, 4 = erase, 5 = write-all, 6 = erase-all) made while `wen_o` is 0 starts no cycle and leaves the array untouched.
- R3: Op code 1 sets `wen_o` and op code 2 clears it. Between those codes, `wen_o` keeps its value across any number of programming cycles.
- R4: A cycle starts only when chip select falls with an accepted request pending. With `SYNC_STAGES` = 2, `busy_o` is still 0 two clock edges after `cs_i` falls and is 1 after the third. It stays high for `BUSY_CYCLES` + 1 cycles for a single-word operation and `BUSY_CYCLES` + 2^`ADDR_W` cycles for a whole-array operation.
- R5: A write stores `req_data_i` at `req_addr_i` and changes no other word.
- R6: An erase stores all ones at the target word and changes no other word.
- R7: Write-all stores the request data in every word, and the writes go in ascending address order starting at 0.
- R8: Erase-all stores all ones in every word.
- R9: If chip select is raised while a cycle runs, `status_oe_o` goes to 1. `status_o` then reads 0 while busy and 1 after the cycle ends, for as long as chip select stays high.
- R10: A rising serial clock edge with chip select and DIN both high clears `status_oe_o`.
- R11: If chip select is first raised only after the cycle has finished, `status_oe_o` stays 0.
- R12: A programming request made while `busy_o` is 1 is discarded and sets `drop_err_o`. The flag stays set until reset, and the running cycle's result is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | One-cycle strobe for a decoded request |
| req_op_i | input | 3 | Request code (1 enable, 2 disable, 3 write, 4 erase, 5 write-all, 6 erase-all) |
| req_addr_i | input | ADDR_W | Target word address |
| req_data_i | input | DATA_W | Data for write and write-all |
| cs_i | input | 1 | Serial chip select (asynchronous) |
| din_i | input | 1 | Serial data input, observed for the status clear |
| sclk_i | input | 1 | Serial clock, observed for the status clear |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | DATA_W | Array write data |
| status_oe_o | output | 1 | Drive enable for the ready/busy report on the data pin |
| status_o | output | 1 | Ready (1) or busy (0) value |
| busy_o | output | 1 | Programming cycle in progress |
| wen_o | output | 1 | Write-enable guard latch |
| drop_err_o | output | 1 | Sticky flag for requests discarded during a cycle |

## Verification
The four programming kinds are each run against an array preloaded with a non-trivial pattern. A single write and a single erase then show whether neighbouring words were disturbed. Write-all, using a pattern that differs from both the preload and all ones, exposes any skipped or reordered address in the walk. The status output is exercised in three ways: chip select raised mid-cycle, chip select raised only after completion, and the clear combination applied while ready is shown. Together these separate the arm, show and clear paths. Requests sent with the latch cleared, and requests sent during a cycle, separate the silent refusal from the flagged drop.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_WEN   = 3'd1,
    OP_WDS   = 3'd2,
    OP_WRITE = 3'd3,
    OP_ERASE = 3'd4,
    OP_WRALL = 3'd5,
    OP_ERAL  = 3'd6
  } prog_op_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_TIME   = 2'd1,
    ST_COMMIT = 2'd2
  } eng_state_e;

  function automatic logic is_prog_op(prog_op_e op);
    return (op == OP_WRITE) || (op == OP_ERASE) || (op == OP_WRALL) || (op == OP_ERAL);
  endfunction

endpackage

// File: rtl/prog_seq_sync.sv
module prog_seq_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/prog_seq_guard.sv
module prog_seq_guard
  import prog_seq_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  prog_op_e          req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic              busy_i,
  input  logic              cs_fall_i,
  output logic              wen_o,
  output logic              drop_err_o,
  output logic              start_o,
  output prog_op_e          pend_op_o,
  output logic [ADDR_W-1:0] pend_addr_o,
  output logic [DATA_W-1:0] pend_data_o
);

  logic wen_q, err_q, pend_q;
  prog_op_e op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wen_q  <= 1'b0;
      err_q  <= 1'b0;
      pend_q <= 1'b0;
      op_q   <= OP_NONE;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      // a pending request lives only until the frame closes
      if (cs_fall_i) pend_q <= 1'b0;
      if (req_valid_i) begin
        if (req_op_i == OP_WEN) begin
          wen_q <= 1'b1;
        end else if (req_op_i == OP_WDS) begin
          wen_q <= 1'b0;
        end else if (is_prog_op(req_op_i)) begin
          if (busy_i) begin
            err_q <= 1'b1;
          end else if (wen_q) begin
            pend_q <= 1'b1;
            op_q   <= req_op_i;
            addr_q <= req_addr_i;
            data_q <= req_data_i;
          end
        end
      end
    end
  end

  assign start_o     = cs_fall_i & pend_q & wen_q & ~busy_i;
  assign wen_o       = wen_q;
  assign drop_err_o  = err_q;
  assign pend_op_o   = op_q;
  assign pend_addr_o = addr_q;
  assign pend_data_o = data_q;

endmodule

// File: rtl/prog_seq_engine.sv
module prog_seq_engine
  import prog_seq_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int BUSY_CYCLES = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  prog_op_e          op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);

  localparam int TW = $clog2(BUSY_CYCLES + 1);
  localparam logic [TW-1:0] TLOAD = TW'(BUSY_CYCLES - 1);

  eng_state_e        st_q;
  logic [TW-1:0]     cnt_q;
  logic              whole_q, fill_q;
  logic [ADDR_W-1:0] tgt_q, cur_q;
  logic [DATA_W-1:0] data_q;
  logic              last;

  assign last = ~whole_q | (&cur_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      whole_q <= 1'b0;
      fill_q  <= 1'b0;
      tgt_q   <= '0;
      cur_q   <= '0;
      data_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q    <= ST_TIME;
          cnt_q   <= TLOAD;
          whole_q <= (op_i == OP_WRALL) || (op_i == OP_ERAL);
          fill_q  <= (op_i == OP_ERASE) || (op_i == OP_ERAL);
          tgt_q   <= addr_i;
          data_q  <= data_i;
        end
        ST_TIME: begin
          if (cnt_q == '0) begin
            st_q  <= ST_COMMIT;
            cur_q <= whole_q ? '0 : tgt_q;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_COMMIT: begin
          if (last) st_q <= ST_IDLE;
          else      cur_q <= cur_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign mem_we_o    = (st_q == ST_COMMIT);
  assign done_o      = mem_we_o & last;
  assign mem_addr_o  = cur_q;
  assign mem_wdata_o = fill_q ? '1 : data_q;

endmodule

// File: rtl/prog_seq_status.sv
module prog_seq_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic done_i,
  input  logic busy_i,
  input  logic cs_rise_i,
  input  logic cs_fall_i,
  input  logic clr_i,
  output logic status_oe_o,
  output logic status_o
);

  logic armed_q, vis_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      vis_q   <= 1'b0;
    end else begin
      if (start_i)                   armed_q <= 1'b1;
      else if (clr_i)                armed_q <= 1'b0;
      else if (done_i && !vis_q)     armed_q <= 1'b0;
      else if (cs_fall_i && !busy_i) armed_q <= 1'b0;

      if (clr_i || cs_fall_i)        vis_q <= 1'b0;
      else if (cs_rise_i && armed_q) vis_q <= 1'b1;
    end
  end

  assign status_oe_o = vis_q;
  assign status_o    = vis_q & ~busy_i;

endmodule

// File: rtl/prog_seq.sv
module prog_seq
  import prog_seq_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int BUSY_CYCLES = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [2:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic              cs_i,
  input  logic              din_i,
  input  logic              sclk_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              status_oe_o,
  output logic              status_o,
  output logic              busy_o,
  output logic              wen_o,
  output logic              drop_err_o
);

  logic [2:0] pins_s;
  logic cs_s, din_s, sclk_s, cs_d, sclk_d;
  logic cs_rise, cs_fall, clr;
  logic start, done, busy;
  prog_op_e pend_op;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_data;

  prog_seq_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_i, din_i, sclk_i}),
    .q_o   (pins_s)
  );

  assign {cs_s, din_s, sclk_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d   <= 1'b0;
      sclk_d <= 1'b0;
    end else begin
      cs_d   <= cs_s;
      sclk_d <= sclk_s;
    end
  end

  assign cs_rise = cs_s & ~cs_d;
  assign cs_fall = ~cs_s & cs_d;
  assign clr     = sclk_s & ~sclk_d & cs_s & din_s;

  prog_seq_guard #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_guard (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_op_i   (prog_op_e'(req_op_i)),
    .req_addr_i (req_addr_i),
    .req_data_i (req_data_i),
    .busy_i     (busy),
    .cs_fall_i  (cs_fall),
    .wen_o      (wen_o),
    .drop_err_o (drop_err_o),
    .start_o    (start),
    .pend_op_o  (pend_op),
    .pend_addr_o(pend_addr),
    .pend_data_o(pend_data)
  );

  prog_seq_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUSY_CYCLES(BUSY_CYCLES)) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .op_i       (pend_op),
    .addr_i     (pend_addr),
    .data_i     (pend_data),
    .busy_o     (busy),
    .done_o     (done),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o)
  );

  prog_seq_status u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .done_i     (done),
    .busy_i     (busy),
    .cs_rise_i  (cs_rise),
    .cs_fall_i  (cs_fall),
    .clr_i      (clr),
    .status_oe_o(status_oe_o),
    .status_o   (status_o)
  );

  assign busy_o = busy;

endmodule

// File: rtl/prog_seq_chk.sv
module prog_seq_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [2:0]        req_op_i,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              status_oe_o,
  input logic              status_o,
  input logic              busy_o,
  input logic              wen_o,
  input logic              drop_err_o
);

  logic prog_req;
  assign prog_req = req_valid_i && (req_op_i >= 3'd3) && (req_op_i <= 3'd6);

  // R2
  cycle_needs_wen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(wen_o));

  // R4
  write_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);

  // R4
  busy_ends_on_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(mem_we_o));

  // R9
  busy_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_oe_o && busy_o) |-> !status_o);

  // R12
  drop_flags_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_req && busy_o) |=> drop_err_o);

  // R12
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_err_o |=> drop_err_o);

endmodule

bind prog_seq prog_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_op_i   (req_op_i),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .status_oe_o(status_oe_o),
  .status_o   (status_o),
  .busy_o     (busy_o),
  .wen_o      (wen_o),
  .drop_err_o (drop_err_o)
);

// File: tb/prog_seq_tb.sv
`timescale 1ns/1ps
module prog_seq_tb;

  localparam int AW = 6;
  localparam int DW = 16;
  localparam int T  = 20;
  localparam int N  = 1 << AW;
  localparam logic [DW-1:0] INIT = 16'hA5A5;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0;
  logic [2:0] req_op_i = 3'd0;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_data_i = '0;
  logic cs_i = 1'b0, din_i = 1'b0, sclk_i = 1'b0;
  logic mem_we_o, status_oe_o, status_o, busy_o, wen_o, drop_err_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o;

  int vectors = 0;
  int miscompares = 0;
  logic [DW-1:0] arr [N];
  int wr_cnt = 0;
  int next_addr = 0;
  logic order_bad = 1'b0;

  always #4 clk_i = ~clk_i;

  prog_seq #(.ADDR_W(AW), .DATA_W(DW), .BUSY_CYCLES(T), .SYNC_STAGES(2)) u_dut (.*);

  always @(posedge clk_i) begin
    if (mem_we_o) begin
      arr[mem_addr_o] <= mem_wdata_o;
      if (int'(mem_addr_o) != next_addr) order_bad <= 1'b1;
      next_addr <= int'(mem_addr_o) + 1;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_op_i = op; req_addr_i = a; req_data_i = d;
    @(negedge clk_i);
    req_valid_i = 1'b0; req_op_i = 3'd0;
  endtask

  // full frame: raise cs, issue request, drop cs; returns on the negedge cs fell
  task automatic frame(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk_i); cs_i = 1'b1;
    repeat (4) @(negedge clk_i);
    send(op, a, d);
    repeat (2) @(negedge clk_i);
    cs_i = 1'b0;
  endtask

  // counts busy cycles after a frame ended
  task automatic run_len(output int n);
    n = 0;
    repeat (3) @(negedge clk_i);
    while (busy_o && n < 1000) begin
      n++;
      @(negedge clk_i);
    end
    repeat (2) @(negedge clk_i);
  endtask

  task automatic preload();
    @(negedge clk_i);
    for (int i = 0; i < N; i++) arr[i] = INIT ^ DW'(i);
  endtask

  task automatic t_reset();
    chk("R1 wen", 32'(wen_o), 0);
    chk("R1 busy", 32'(busy_o), 0);
    chk("R1 err", 32'(drop_err_o), 0);
    chk("R1 oe", 32'(status_oe_o), 0);
    chk("R1 we", 32'(mem_we_o), 0);
  endtask

  task automatic t_locked();
    int n;
    frame(3'd3, 6'd5, 16'h1234);
    run_len(n);
    chk("R2 no cycle while locked", 32'(n), 0);
    chk("R2 word kept", 32'(arr[5]), 32'(INIT ^ 16'd5));
  endtask

  task automatic t_enable();
    frame(3'd1, '0, '0);
    repeat (4) @(negedge clk_i);
    chk("R3 enable sets latch", 32'(wen_o), 1);
  endtask

  task automatic t_write();
    int n;
    frame(3'd3, 6'd5, 16'h1234);
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R4 busy not yet", 32'(busy_o), 0);
    @(negedge clk_i);
    chk("R4 busy on third edge", 32'(busy_o), 1);
    n = 0;
    while (busy_o && n < 1000) begin n++; @(negedge clk_i); end
    chk("R4 single length", 32'(n), 32'(T + 1));
    @(negedge clk_i);
    chk("R5 target written", 32'(arr[5]), 32'h1234);
    chk("R5 lower neighbour", 32'(arr[4]), 32'(INIT ^ 16'd4));
    chk("R5 upper neighbour", 32'(arr[6]), 32'(INIT ^ 16'd6));
    chk("R3 latch holds", 32'(wen_o), 1);
  endtask

  task automatic t_erase();
    int n;
    frame(3'd4, 6'd9, 16'h0000);
    run_len(n);
    chk("R6 erased word", 32'(arr[9]), 32'hFFFF);
    chk("R6 neighbour", 32'(arr[8]), 32'(INIT ^ 16'd8));
  endtask

  task automatic t_nopend();
    int n;
    @(negedge clk_i); cs_i = 1'b1;
    repeat (5) @(negedge clk_i);
    cs_i = 1'b0;
    run_len(n);
    chk("R4 no request no cycle", 32'(n), 0);
  endtask

  task automatic t_status();
    frame(3'd3, 6'd10, 16'h0F0F);
    repeat (6) @(negedge clk_i);
    cs_i = 1'b1;
    repeat (4) @(negedge clk_i);
    chk("R9 oe during busy", 32'(status_oe_o), 1);
    chk("R9 reads busy", 32'(status_o), 0);
    while (busy_o) @(negedge clk_i);
    @(negedge clk_i);
    chk("R9 oe after done", 32'(status_oe_o), 1);
    chk("R9 reads ready", 32'(status_o), 1);
    din_i = 1'b1;
    @(negedge clk_i); sclk_i = 1'b1;
    repeat (4) @(negedge clk_i);
    chk("R10 cleared", 32'(status_oe_o), 0);
    sclk_i = 1'b0; din_i = 1'b0; cs_i = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic t_late();
    int n;
    frame(3'd3, 6'd11, 16'h7777);
    run_len(n);
    cs_i = 1'b1;
    repeat (5) @(negedge clk_i);
    chk("R11 no late status", 32'(status_oe_o), 0);
    cs_i = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic t_drop();
    frame(3'd3, 6'd12, 16'h1111);
    repeat (6) @(negedge clk_i);
    cs_i = 1'b1;
    send(3'd4, 6'd12, 16'h0000);
    @(negedge clk_i);
    chk("R12 drop flagged", 32'(drop_err_o), 1);
    cs_i = 1'b0;
    while (busy_o) @(negedge clk_i);
    repeat (6) @(negedge clk_i);
    chk("R12 running result kept", 32'(arr[12]), 32'h1111);
    chk("R12 no second cycle", 32'(busy_o), 0);
  endtask

  task automatic t_wrall();
    int n, bad;
    @(negedge clk_i);
    order_bad = 1'b0; next_addr = 0; wr_cnt = 0;
    frame(3'd5, '0, 16'hBEEF);
    run_len(n);
    chk("R4 whole length", 32'(n), 32'(T + N));
    bad = 0;
    for (int i = 0; i < N; i++) if (arr[i] !== 16'hBEEF) bad++;
    chk("R7 all words pattern", 32'(bad), 0);
    chk("R7 ascending from zero", 32'(order_bad), 0);
    chk("R7 write count", 32'(wr_cnt), 32'(N));
  endtask

  task automatic t_eral();
    int n, bad;
    frame(3'd6, '0, '0);
    run_len(n);
    bad = 0;
    for (int i = 0; i < N; i++) if (arr[i] !== 16'hFFFF) bad++;
    chk("R8 all ones", 32'(bad), 0);
  endtask

  task automatic t_disable();
    int n;
    frame(3'd2, '0, '0);
    repeat (4) @(negedge clk_i);
    chk("R3 disable clears", 32'(wen_o), 0);
    frame(3'd3, 6'd3, 16'h0000);
    run_len(n);
    chk("R2 locked again", 32'(n), 0);
    chk("R2 word intact", 32'(arr[3]), 32'hFFFF);
    chk("R12 flag still set", 32'(drop_err_o), 1);
  endtask

  logic done_run = 1'b0;

  initial begin
    preload();
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_locked();
    t_enable();
    t_write();
    t_erase();
    t_nopend();
    t_status();
    t_late();
    t_drop();
    t_wrall();
    t_eral();
    t_disable();
    done_run = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done_run) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule